// File: doc/BRIEF.md
# Interrupt Acceptance Unit with Dual Enable Flip-Flops

This block decides, at each instruction boundary of an 8-bit processor core, whether an interrupt is taken, which kind it is, where the handler starts and how many T-states the acknowledge sequence costs. It keeps two interrupt-enable flip-flops. The primary one gates maskable requests. The shadow one preserves the enable state across a non-maskable entry, so that an ED-page return can restore it. The unit also holds the interrupt mode and a halt state.

The decoder reports the completed instruction as one-cycle event strobes, qualified by `insn_end`. When an interrupt is taken, the unit gives a one-cycle acknowledge in the cycle after the boundary edge. With that acknowledge it gives the kind, the target or vector-fetch address, and the cost. Instruction fetch, the stack push and program-counter arithmetic stay outside the block; when a halt ends, the unit only tells the fetch logic to step over the HALT.

Top module: `irq_ctl`

## Requirements
- R1: After reset both enable flip-flops are 0, the interrupt mode is 0, `halted` is 0 and `ack` is 0.
- R2: A boundary carrying `ev_di` clears both enable flip-flops. A boundary carrying `ev_ei` sets both.
- R3: `int_req_n` is a level. A maskable request is taken only at a boundary, only while it is low and only while the primary enable (after any return at that boundary) is 1. Taking it clears both enable flip-flops. A high level is never taken.
- R4: A high-to-low transition of `nmi_req_n` is latched as pending. A pulse lasting one clock is therefore kept until the next open boundary. A pending NMI is taken whatever the enables are, with kind 3, address 0066h and cost 11. Taking it clears the primary enable, leaves the shadow enable unchanged and clears the pending flag. A line held low gives only one acknowledge.
- R5: When an NMI is pending and a maskable request is also valid at the same boundary, the NMI is taken.
- R6: A boundary carrying `ev_retn` (any ED-page return) copies the shadow enable into the primary enable.
- R7: `ev_im` with `im_sel` selects the mode: 0 gives mode 0, 1 gives mode 1, 2 gives mode 2, and 3 gives mode 0. Each mode has its own kind code, address and cost:
  - Mode 0: kind 0, address 00h:bus byte (the opcode to execute), cost 13.
  - Mode 1: kind 1, address 0038h, cost 13.
  - Mode 2: kind 2, address `i_reg`:bus byte, cost 19.
- R8: No interrupt is taken at a boundary that carries `ev_ei`, `ev_di` or `ev_pfx`. A pending NMI or a low maskable request is taken at the next open boundary.
- R9: Interrupts are taken only on cycles with `insn_end` high. `ack` is a single-cycle pulse.
- R10: A boundary carrying `ev_halt` sets `halted` unless an interrupt is taken there. `halted` stays 1 across further boundaries until an interrupt is taken. That acknowledge asserts `halt_exit` and clears `halted`. An acknowledge outside a halt leaves `halt_exit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req_n | input | 1 | Maskable request level, active low |
| nmi_req_n | input | 1 | Non-maskable request line, falling edge active |
| insn_end | input | 1 | Instruction boundary strobe |
| ev_di | input | 1 | Completed instruction was DI |
| ev_ei | input | 1 | Completed instruction was EI |
| ev_retn | input | 1 | Completed instruction was an ED-page return |
| ev_pfx | input | 1 | Completed byte was an index prefix |
| ev_halt | input | 1 | Completed instruction was HALT |
| ev_im | input | 1 | Completed instruction set the interrupt mode |
| im_sel | input | 2 | Mode operand of the mode-set instruction |
| bus_vec | input | 8 | Data-bus byte supplied by the interrupting device |
| i_reg | input | 8 | Interrupt page register |
| ack | output | 1 | Interrupt accepted, one-cycle pulse |
| ack_kind | output | 2 | 0/1/2 = maskable mode 0/1/2, 3 = NMI |
| ack_addr | output | 16 | Handler target, vector-fetch address or mode-0 opcode |
| ack_cost | output | 5 | T-states of the acknowledge |
| iff1 | output | 1 | Primary enable flip-flop |
| iff2 | output | 1 | Shadow enable, copied into P/V by the core |
| halted | output | 1 | Halt indication |
| halt_exit | output | 1 | Acknowledge ended a halt; fetch steps past HALT |

## Verification
The bench first runs a sweep over every mode operand and a spread of bus bytes and page values. It then goes after the traps of the two enable flip-flops:
- An NMI entry that also cleared the shadow enable would show 0 on `iff2` and lose the enable state when the return runs.
- A level-sensitive NMI would acknowledge again while the line stays low.
- A one-clock NMI pulse that is not latched would never be taken.
- A design that ignores EI, DI or prefix boundaries would acknowledge one boundary early.

The halt case checks that `halted` survives several boundaries and clears only with the acknowledge that raises `halt_exit`.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    IRQ_KIND_M0  = 2'd0,
    IRQ_KIND_M1  = 2'd1,
    IRQ_KIND_M2  = 2'd2,
    IRQ_KIND_NMI = 2'd3
  } irq_kind_e;

  // Mode operand 3 behaves as mode 0.
  function automatic logic [1:0] im_decode(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd0 : sel;
  endfunction

  function automatic logic falling(input logic prev, input logic now);
    return prev & ~now;
  endfunction

  function automatic irq_kind_e mode_kind(input logic [1:0] mode);
    case (mode)
      2'd1:    return IRQ_KIND_M1;
      2'd2:    return IRQ_KIND_M2;
      default: return IRQ_KIND_M0;
    endcase
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take_nmi,
  output logic pend,
  output logic fall
);
  logic prev_q;

  always_comb fall = irq_ctl_pkg::falling(prev_q, nmi_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      pend   <= (pend & ~take_nmi) | fall;
    end
  end
endmodule

// File: rtl/irq_iff_regs.sv
module irq_iff_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       ev_di,
  input  logic       ev_ei,
  input  logic       ev_retn,
  input  logic       ev_im,
  input  logic [1:0] im_sel,
  input  logic       take_nmi,
  input  logic       take_int,
  output logic       iff1,
  output logic       iff2,
  output logic       iff1_eff,
  output logic [1:0] mode_eff
);
  logic [1:0] mode_q;

  // State as left by the instruction that completes at this boundary.
  always_comb begin
    iff1_eff = (boundary & ev_retn) ? iff2 : iff1;
    mode_eff = (boundary & ev_im) ? irq_ctl_pkg::im_decode(im_sel) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1   <= 1'b0;
      iff2   <= 1'b0;
      mode_q <= 2'd0;
    end else begin
      mode_q <= mode_eff;
      if (take_int) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (take_nmi) begin
        iff1 <= 1'b0;
      end else if (boundary) begin
        if (ev_di) begin
          iff1 <= 1'b0;
          iff2 <= 1'b0;
        end else if (ev_ei) begin
          iff1 <= 1'b1;
          iff2 <= 1'b1;
        end else if (ev_retn) begin
          iff1 <= iff2;
        end
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2 * DATA_W,
  parameter int unsigned COST_W = 5,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 'h0066,
  parameter logic [ADDR_W-1:0] RST_ADDR = 'h0038,
  parameter int unsigned COST_M0  = 13,
  parameter int unsigned COST_M1  = 13,
  parameter int unsigned COST_M2  = 19,
  parameter int unsigned COST_NMI = 11
) (
  input  logic              boundary,
  input  logic              blocked,
  input  logic              nmi_pend,
  input  logic              int_n,
  input  logic              iff1_eff,
  input  logic [1:0]        mode_eff,
  input  logic [DATA_W-1:0] bus_vec,
  input  logic [DATA_W-1:0] i_reg,
  output logic              take_nmi,
  output logic              take_int,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] target,
  output logic [COST_W-1:0] cost
);
  import irq_ctl_pkg::*;

  logic      open_w;
  irq_kind_e kind_w;

  always_comb begin
    open_w   = boundary & ~blocked;
    take_nmi = open_w & nmi_pend;
    take_int = open_w & ~nmi_pend & ~int_n & iff1_eff;
    kind_w   = nmi_pend ? IRQ_KIND_NMI : mode_kind(mode_eff);
    kind     = kind_w;
    case (kind_w)
      IRQ_KIND_NMI: begin
        target = NMI_ADDR;
        cost   = COST_W'(COST_NMI);
      end
      IRQ_KIND_M1: begin
        target = RST_ADDR;
        cost   = COST_W'(COST_M1);
      end
      IRQ_KIND_M2: begin
        target = {i_reg, bus_vec};
        cost   = COST_W'(COST_M2);
      end
      default: begin
        target = ADDR_W'(bus_vec);
        cost   = COST_W'(COST_M0);
      end
    endcase
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COST_W = 5,
  parameter logic [2*DATA_W-1:0] NMI_ADDR = 'h0066,
  parameter logic [2*DATA_W-1:0] RST_ADDR = 'h0038,
  parameter int unsigned COST_M0  = 13,
  parameter int unsigned COST_M1  = 13,
  parameter int unsigned COST_M2  = 19,
  parameter int unsigned COST_NMI = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  int_req_n,
  input  logic                  nmi_req_n,
  input  logic                  insn_end,
  input  logic                  ev_di,
  input  logic                  ev_ei,
  input  logic                  ev_retn,
  input  logic                  ev_pfx,
  input  logic                  ev_halt,
  input  logic                  ev_im,
  input  logic [1:0]            im_sel,
  input  logic [DATA_W-1:0]     bus_vec,
  input  logic [DATA_W-1:0]     i_reg,
  output logic                  ack,
  output logic [1:0]            ack_kind,
  output logic [2*DATA_W-1:0]   ack_addr,
  output logic [COST_W-1:0]     ack_cost,
  output logic                  iff1,
  output logic                  iff2,
  output logic                  halted,
  output logic                  halt_exit
);
  localparam int unsigned ADDR_W = 2 * DATA_W;

  // Named internal events, also watched by the checker.
  logic              nmi_pend, nmi_fall;
  logic              take_nmi, take_int, take_any;
  logic              blocked, iff1_eff;
  logic [1:0]        mode_eff, kind_w;
  logic [ADDR_W-1:0] target_w;
  logic [COST_W-1:0] cost_w;
  logic              halt_now;

  always_comb begin
    blocked  = ev_ei | ev_di | ev_pfx;
    take_any = take_nmi | take_int;
    halt_now = insn_end & ev_halt;
  end

  irq_nmi_latch nmi_i (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_req_n),
    .take_nmi(take_nmi), .pend(nmi_pend), .fall(nmi_fall)
  );

  irq_iff_regs iff_i (
    .clk(clk), .rst_n(rst_n), .boundary(insn_end),
    .ev_di(ev_di), .ev_ei(ev_ei), .ev_retn(ev_retn),
    .ev_im(ev_im), .im_sel(im_sel),
    .take_nmi(take_nmi), .take_int(take_int),
    .iff1(iff1), .iff2(iff2), .iff1_eff(iff1_eff), .mode_eff(mode_eff)
  );

  irq_arbiter #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COST_W(COST_W),
    .NMI_ADDR(NMI_ADDR), .RST_ADDR(RST_ADDR),
    .COST_M0(COST_M0), .COST_M1(COST_M1), .COST_M2(COST_M2), .COST_NMI(COST_NMI)
  ) arb_i (
    .boundary(insn_end), .blocked(blocked), .nmi_pend(nmi_pend),
    .int_n(int_req_n), .iff1_eff(iff1_eff), .mode_eff(mode_eff),
    .bus_vec(bus_vec), .i_reg(i_reg),
    .take_nmi(take_nmi), .take_int(take_int),
    .kind(kind_w), .target(target_w), .cost(cost_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      ack_kind  <= 2'd0;
      ack_addr  <= '0;
      ack_cost  <= '0;
      halted    <= 1'b0;
      halt_exit <= 1'b0;
    end else begin
      ack       <= take_any;
      halt_exit <= take_any & (halted | halt_now);
      if (take_any) begin
        ack_kind <= kind_w;
        ack_addr <= target_w;
        ack_cost <= cost_w;
        halted   <= 1'b0;
      end else if (halt_now) begin
        halted   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COST_W = 5,
  parameter logic [2*DATA_W-1:0] NMI_ADDR = 'h0066,
  parameter int unsigned COST_M2  = 19,
  parameter int unsigned COST_NMI = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                insn_end,
  input logic                ev_di,
  input logic                ev_ei,
  input logic                ev_pfx,
  input logic                int_req_n,
  input logic [DATA_W-1:0]   i_reg,
  input logic                ack,
  input logic [1:0]          ack_kind,
  input logic [2*DATA_W-1:0] ack_addr,
  input logic [COST_W-1:0]   ack_cost,
  input logic                iff1,
  input logic                iff2,
  input logic                halted,
  input logic                halt_exit,
  input logic                take_nmi,
  input logic                nmi_pend
);
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_end)); // R9

  AST_BLOCKED_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && (ev_ei || ev_di || ev_pfx)) |=> !ack); // R8

  AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_kind == 2'd3) |-> (!iff1 && iff2 == $past(iff2))); // R4

  AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_kind == 2'd3) |-> (ack_addr == NMI_ADDR && ack_cost == COST_W'(COST_NMI))); // R4

  AST_NMI_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> nmi_pend); // R4

  AST_INT_CLEARS_IFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_kind != 2'd3) |-> (!iff1 && !iff2 && $past(!int_req_n))); // R3

  AST_MODE2_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_kind == 2'd2) |-> (ack_addr[2*DATA_W-1:DATA_W] == $past(i_reg) && ack_cost == COST_W'(COST_M2))); // R7

  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_exit |-> (ack && !halted)); // R10
endmodule

bind irq_ctl irq_ctl_chk #(
  .DATA_W(DATA_W), .COST_W(COST_W), .NMI_ADDR(NMI_ADDR),
  .COST_M2(COST_M2), .COST_NMI(COST_NMI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .insn_end(insn_end),
  .ev_di(ev_di), .ev_ei(ev_ei), .ev_pfx(ev_pfx),
  .int_req_n(int_req_n), .i_reg(i_reg),
  .ack(ack), .ack_kind(ack_kind), .ack_addr(ack_addr), .ack_cost(ack_cost),
  .iff1(iff1), .iff2(iff2), .halted(halted), .halt_exit(halt_exit),
  .take_nmi(take_nmi), .nmi_pend(nmi_pend)
);

// File: tb/irq_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_ctl_tb_top;
  localparam int E_DI = 0, E_EI = 1, E_RETN = 2, E_PFX = 3, E_HALT = 4, E_IM = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_req_n = 1'b1, nmi_req_n = 1'b1, insn_end = 1'b0;
  logic        ev_di = 0, ev_ei = 0, ev_retn = 0, ev_pfx = 0, ev_halt = 0, ev_im = 0;
  logic [1:0]  im_sel = 2'd0;
  logic [7:0]  bus_vec = 8'h00, i_reg = 8'h00;
  logic        ack, iff1, iff2, halted, halt_exit;
  logic [1:0]  ack_kind;
  logic [15:0] ack_addr;
  logic [4:0]  ack_cost;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .int_req_n(int_req_n), .nmi_req_n(nmi_req_n),
    .insn_end(insn_end), .ev_di(ev_di), .ev_ei(ev_ei), .ev_retn(ev_retn),
    .ev_pfx(ev_pfx), .ev_halt(ev_halt), .ev_im(ev_im), .im_sel(im_sel),
    .bus_vec(bus_vec), .i_reg(i_reg), .ack(ack), .ack_kind(ack_kind),
    .ack_addr(ack_addr), .ack_cost(ack_cost), .iff1(iff1), .iff2(iff2),
    .halted(halted), .halt_exit(halt_exit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One instruction boundary; called and returns at a falling edge.
  task automatic insn(input logic [5:0] ev, input logic [1:0] ims);
    insn_end = 1'b1;
    ev_di = ev[E_DI]; ev_ei = ev[E_EI]; ev_retn = ev[E_RETN];
    ev_pfx = ev[E_PFX]; ev_halt = ev[E_HALT]; ev_im = ev[E_IM]; im_sel = ims;
    @(posedge clk); @(negedge clk);
    insn_end = 1'b0;
    ev_di = 0; ev_ei = 0; ev_retn = 0; ev_pfx = 0; ev_halt = 0; ev_im = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nmi_pulse();
    nmi_req_n = 1'b0; idle(1); nmi_req_n = 1'b1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 iff1", iff1, 0); chk("R1 iff2", iff2, 0);
    chk("R1 halted", halted, 0); chk("R1 ack", ack, 0);

    // Masked request ignored.
    int_req_n = 1'b0; bus_vec = 8'hC7;
    insn(6'b0, 2'd0);
    chk("R3 masked", ack, 0);
    insn(6'b1 << E_EI, 2'd0);
    chk("R2 ei iff1", iff1, 1); chk("R2 ei iff2", iff2, 1);
    chk("R8 after EI", ack, 0);
    insn(6'b0, 2'd0);
    chk("R1 reset mode kind", ack_kind, 0); chk("R3 ack", ack, 1);
    chk("R7 m0 addr", ack_addr, 16'h00C7); chk("R7 m0 cost", ack_cost, 13);
    chk("R3 iff1 cleared", iff1, 0); chk("R3 iff2 cleared", iff2, 0);
    chk("R10 no halt exit", halt_exit, 0);
    int_req_n = 1'b1;
    idle(1);
    chk("R9 pulse", ack, 0);
    insn(6'b1 << E_EI, 2'd0); insn(6'b1 << E_DI, 2'd0);
    chk("R2 di iff1", iff1, 0); chk("R2 di iff2", iff2, 0);

    // Mode sweep.
    for (int sel = 0; sel < 4; sel++) begin
      insn(6'b1 << E_IM, sel[1:0]);
      for (int b = 0; b < 256; b += 51) begin
        logic [1:0]  em;
        logic [15:0] ea;
        em = (sel == 3) ? 2'd0 : sel[1:0];
        ea = (em == 2'd0) ? {8'h00, b[7:0]} : (em == 2'd1) ? 16'h0038 : {~b[7:0], b[7:0]};
        insn(6'b1 << E_EI, 2'd0);
        bus_vec = b[7:0]; i_reg = ~b[7:0];
        insn(6'b0, 2'd0);
        chk("R3 level high ignored", ack, 0);
        int_req_n = 1'b0;
        insn(6'b0, 2'd0);
        chk("R7 ack", ack, 1); chk("R7 kind", ack_kind, em);
        chk("R7 addr", ack_addr, ea); chk("R7 cost", ack_cost, (em == 2'd2) ? 19 : 13);
        int_req_n = 1'b1;
        idle(1);
        chk("R9 single pulse", ack, 0);
      end
    end

    // NMI entry with enables set and a simultaneous maskable request.
    insn(6'b1 << E_EI, 2'd0);
    nmi_req_n = 1'b0; int_req_n = 1'b0;
    idle(1);
    insn(6'b0, 2'd0);
    chk("R5 nmi wins", ack_kind, 3); chk("R4 ack", ack, 1);
    chk("R4 addr", ack_addr, 16'h0066); chk("R4 cost", ack_cost, 11);
    chk("R4 iff1", iff1, 0); chk("R4 iff2 kept", iff2, 1);
    insn(6'b0, 2'd0);
    chk("R4 held low once", ack, 0);
    int_req_n = 1'b1;
    insn(6'b1 << E_RETN, 2'd0);
    chk("R6 restore iff1", iff1, 1); chk("R6 iff2", iff2, 1);
    nmi_req_n = 1'b1;
    insn(6'b1 << E_DI, 2'd0);
    insn(6'b1 << E_RETN, 2'd0);
    chk("R6 copy zero", iff1, 0);

    // Short pulse while disabled.
    nmi_pulse(); idle(3);
    insn(6'b0, 2'd0);
    chk("R4 pulse latched", ack, 1); chk("R4 pulse kind", ack_kind, 3);
    chk("R4 iff2 zero kept", iff2, 0);

    // Blocking boundaries.
    nmi_pulse();
    insn(6'b1 << E_PFX, 2'd0);
    chk("R8 prefix blocks", ack, 0);
    insn(6'b0, 2'd0);
    chk("R8 nmi after prefix", ack, 1);
    nmi_pulse();
    insn(6'b1 << E_DI, 2'd0);
    chk("R8 di blocks", ack, 0);
    insn(6'b0, 2'd0);
    chk("R8 nmi after di", ack_kind & {2{ack}}, 3);
    int_req_n = 1'b0;
    insn(6'b1 << E_EI, 2'd0);
    chk("R8 ei blocks", ack, 0);
    insn(6'b0, 2'd0);
    chk("R8 int after ei", ack, 1);
    int_req_n = 1'b1;

    // Halt.
    insn(6'b1 << E_EI, 2'd0);
    insn(6'b1 << E_HALT, 2'd0);
    chk("R10 halted", halted, 1); chk("R10 no ack", ack, 0);
    for (int k = 0; k < 3; k++) begin
      insn(6'b0, 2'd0);
      chk("R10 stays halted", halted, 1);
    end
    int_req_n = 1'b0;
    insn(6'b0, 2'd0);
    chk("R10 ack", ack, 1); chk("R10 exit", halt_exit, 1);
    chk("R10 released", halted, 0);
    int_req_n = 1'b1;
    idle(2);
    report();
  end
endmodule